// File: doc/BRIEF.md
# Slave-Serial Configuration Loader

This block configures a programmable logic device over its four-wire slave-serial interface. A bitstream image sits in a byte-wide source memory. After a single start pulse, the loader searches the image for the first synchronisation byte (0xFF) and checks the tag nibble that follows it. It then decodes a 24-bit bit count and confirms that the image is long enough to hold the number of bytes that count implies.

Only when the header is acceptable does it touch the target. It pulses the program line low, waits for the target to clear, and checks that the status line has dropped. It then clocks every byte from the sync byte to the end of the image out MSB first. After a settle interval it samples the status line again.

All waits are counted in ticks of an external millisecond strobe, so the block needs no knowledge of the clock rate. The outcome is reported as a one-cycle finish strobe, together with a pass flag and a three-bit reason code. Both stay valid until the next start.

Top module: `ssl_loader`

## Requirements
- R1: Out of reset and whenever the loader is idle, the enable output is low, the program line is high, and the serial clock and data outputs are low.
- R2: The loader scans addresses 0 to length-1 for the first byte equal to 0xFF. If none is found, which includes the case of length 0, it finishes with reason code 1 and never drives the program line low.
- R3: The byte after the sync byte must carry 0x2 in bits 7:4; bits 3:0 may hold any value. Any other upper nibble ends the run with reason code 2 and no program pulse.
- R4: The bit count is assembled from the four bytes after the sync byte: bits 3:0 of the first go to count[23:20], the second to [19:12], the third to [11:4], and bits 7:4 of the fourth to [3:0]. If sync index + floor(count/8) exceeds the image length, the run ends with reason code 3 before any pin activity.
- R5: Configuration opens with the program line low for exactly one clock cycle and then high. The loader then waits for CLEAR_MS tick strobes.
- R6: After the clear wait, a high status input ends the run with reason code 4, and no serial clock pulse is produced.
- R7: Bytes from the sync index through length-1 are sent MSB first. Each bit is placed on the data output while the serial clock is low. The serial clock is then high for exactly two cycles, and the data output is stable during that time.
- R8: After the last bit the loader waits SETTLE_MS tick strobes and samples the status input. High gives pass with reason code 0; low gives fail with reason code 5.
- R9: The enable output is high from start until the run returns to idle. The finish output is a single-cycle pulse. The pass flag and reason code stay valid after finish until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that begins a run |
| img_len_i | input | ADDR_W | Image length in bytes, sampled at start |
| mem_addr_o | output | ADDR_W | Source memory byte address |
| mem_rdata_i | input | 8 | Source memory data, one cycle after the address |
| tick_i | input | 1 | Millisecond strobe, one cycle wide |
| cfg_en_o | output | 1 | Target interface enable |
| cfg_prog_n_o | output | 1 | Target program line, active low |
| cfg_cclk_o | output | 1 | Target serial clock |
| cfg_din_o | output | 1 | Target serial data |
| cfg_done_i | input | 1 | Target status line (low while busy, high when configured) |
| busy_o | output | 1 | A run is in progress |
| fin_o | output | 1 | One-cycle strobe when a run ends |
| pass_o | output | 1 | Last run succeeded |
| err_o | output | 3 | Reason code: 0 ok, 1 no sync, 2 bad tag, 3 image short, 4 clear not acknowledged, 5 stuck busy |

## Verification
The hardest situations to reach are the two status-line failures. Both sit behind a complete, valid header and a full tick-timed wait. They differ only in how the target behaves at one sampling moment. The bench contains a behavioural target that follows the program pulse and counts received bits. It can be told to hold its status high through the clear wait, or to never raise it after the last bit. The same valid image is reused so that only the target's response changes. The size boundary is approached from both sides with a count whose low three bits are non-zero, so that floor division and an off-by-one comparison give different outcomes.

// File: rtl/ssl_pkg.sv
package ssl_pkg;
  localparam int BCNT_W    = 24;
  localparam int HDR_BYTES = 4;
  localparam logic [7:0] SYNC_BYTE = 8'hFF;
  localparam logic [3:0] HDR_TAG   = 4'h2;

  typedef enum logic [2:0] {
    ERR_NONE     = 3'd0,
    ERR_NO_SYNC  = 3'd1,
    ERR_HDR_BAD  = 3'd2,
    ERR_SHORT    = 3'd3,
    ERR_CLR_NACK = 3'd4,
    ERR_STUCK    = 3'd5
  } err_e;

  typedef enum logic [3:0] {
    S_IDLE, S_SCAN_RD, S_SCAN_CAP, S_HDR_RD, S_HDR_CAP, S_SIZE, S_PROG,
    S_CLR_WAIT, S_SH_RD, S_SH_CAP, S_SH_RUN, S_DONE_WAIT, S_FIN
  } st_e;
endpackage

// File: rtl/ssl_tick_timer.sv
module ssl_tick_timer #(
  parameter int LIMIT = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic expired_o
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (!run_i)                cnt_q <= '0;
    else if (tick_i && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q == LIM);
endmodule

// File: rtl/ssl_bit_shifter.sv
module ssl_bit_shifter #(
  parameter int WORD_W = 8,
  parameter int HI_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              cclk_o,
  output logic              din_o,
  output logic              last_o
);
  // per bit: setup low, HI_CYC high, trailing low
  localparam int PH_N  = HI_CYC + 2;
  localparam int PH_W  = $clog2(PH_N);
  localparam int BIT_W = $clog2(WORD_W);

  logic [PH_W-1:0]   ph_q;
  logic [BIT_W-1:0]  bit_q;
  logic [WORD_W-1:0] sh_q;
  logic              act_q;
  logic              ph_end, word_end;

  assign ph_end   = (ph_q == PH_W'(PH_N - 1));
  assign word_end = (bit_q == BIT_W'(WORD_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= '0;
      bit_q <= '0;
      sh_q  <= '0;
      act_q <= 1'b0;
    end else if (load_i) begin
      ph_q  <= '0;
      bit_q <= '0;
      sh_q  <= data_i;
      act_q <= 1'b1;
    end else if (act_q) begin
      if (ph_end) begin
        ph_q <= '0;
        if (word_end) begin
          act_q <= 1'b0;
          sh_q  <= '0;
        end else begin
          bit_q <= bit_q + 1'b1;
          sh_q  <= {sh_q[WORD_W-2:0], 1'b0};
        end
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end

  assign cclk_o = act_q && (ph_q != '0) && (ph_q <= PH_W'(HI_CYC));
  assign din_o  = act_q && sh_q[WORD_W-1];
  assign last_o = act_q && ph_end && word_end;
endmodule

// File: rtl/ssl_loader.sv
module ssl_loader
  import ssl_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int CLEAR_MS  = 50,
  parameter int SETTLE_MS = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] img_len_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_rdata_i,
  input  logic              tick_i,
  output logic              cfg_en_o,
  output logic              cfg_prog_n_o,
  output logic              cfg_cclk_o,
  output logic              cfg_din_o,
  input  logic              cfg_done_i,
  output logic              busy_o,
  output logic              fin_o,
  output logic              pass_o,
  output logic [2:0]        err_o
);
  localparam int CNT_BYTE_W = BCNT_W - 3;
  localparam int SUM_W = ((ADDR_W > CNT_BYTE_W) ? ADDR_W : CNT_BYTE_W) + 1;
  localparam int HK_W  = $clog2(HDR_BYTES);

  st_e               st_q;
  err_e              err_q;
  logic              pass_q;
  logic [ADDR_W-1:0] idx_q, sync_q, len_q;
  logic [HK_W-1:0]   hk_q;
  logic [BCNT_W-1:0] bcnt_q;
  logic [SUM_W-1:0]  need_w;
  logic              clr_exp, set_exp, sh_last;

  assign need_w = SUM_W'(sync_q) + SUM_W'(bcnt_q >> 3);

  ssl_tick_timer #(.LIMIT(CLEAR_MS)) i_clr_tmr (
    .clk_i, .rst_ni, .run_i(st_q == S_CLR_WAIT), .tick_i, .expired_o(clr_exp)
  );

  ssl_tick_timer #(.LIMIT(SETTLE_MS)) i_set_tmr (
    .clk_i, .rst_ni, .run_i(st_q == S_DONE_WAIT), .tick_i, .expired_o(set_exp)
  );

  ssl_bit_shifter #(.WORD_W(8), .HI_CYC(2)) i_shf (
    .clk_i, .rst_ni,
    .load_i (st_q == S_SH_CAP),
    .data_i (mem_rdata_i),
    .cclk_o (cfg_cclk_o),
    .din_o  (cfg_din_o),
    .last_o (sh_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      err_q  <= ERR_NONE;
      pass_q <= 1'b0;
      idx_q  <= '0;
      sync_q <= '0;
      len_q  <= '0;
      hk_q   <= '0;
      bcnt_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (start_i) begin
          idx_q  <= '0;
          len_q  <= img_len_i;
          pass_q <= 1'b0;
          err_q  <= ERR_NONE;
          st_q   <= S_SCAN_RD;
        end
        S_SCAN_RD: begin
          if (idx_q >= len_q) begin
            err_q <= ERR_NO_SYNC;
            st_q  <= S_FIN;
          end else st_q <= S_SCAN_CAP;
        end
        S_SCAN_CAP: begin
          idx_q <= idx_q + 1'b1;
          if (mem_rdata_i == SYNC_BYTE) begin
            sync_q <= idx_q;
            hk_q   <= '0;
            st_q   <= S_HDR_RD;
          end else st_q <= S_SCAN_RD;
        end
        S_HDR_RD: st_q <= S_HDR_CAP;
        S_HDR_CAP: begin
          unique case (hk_q)
            2'd0: bcnt_q[23:20] <= mem_rdata_i[3:0];
            2'd1: bcnt_q[19:12] <= mem_rdata_i;
            2'd2: bcnt_q[11:4]  <= mem_rdata_i;
            default: bcnt_q[3:0] <= mem_rdata_i[7:4];
          endcase
          if (hk_q == '0 && mem_rdata_i[7:4] != HDR_TAG) begin
            err_q <= ERR_HDR_BAD;
            st_q  <= S_FIN;
          end else if (hk_q == HK_W'(HDR_BYTES - 1)) begin
            st_q <= S_SIZE;
          end else begin
            hk_q  <= hk_q + 1'b1;
            idx_q <= idx_q + 1'b1;
            st_q  <= S_HDR_RD;
          end
        end
        S_SIZE: begin
          if (need_w > SUM_W'(len_q)) begin
            err_q <= ERR_SHORT;
            st_q  <= S_FIN;
          end else st_q <= S_PROG;
        end
        S_PROG: st_q <= S_CLR_WAIT;
        S_CLR_WAIT: if (clr_exp) begin
          if (cfg_done_i) begin
            err_q <= ERR_CLR_NACK;
            st_q  <= S_FIN;
          end else begin
            idx_q <= sync_q;
            st_q  <= S_SH_RD;
          end
        end
        S_SH_RD:  st_q <= S_SH_CAP;
        S_SH_CAP: st_q <= S_SH_RUN;
        S_SH_RUN: if (sh_last) begin
          if (idx_q + 1'b1 == len_q) st_q <= S_DONE_WAIT;
          else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= S_SH_RD;
          end
        end
        S_DONE_WAIT: if (set_exp) begin
          pass_q <= cfg_done_i;
          err_q  <= cfg_done_i ? ERR_NONE : ERR_STUCK;
          st_q   <= S_FIN;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign mem_addr_o   = idx_q;
  assign cfg_en_o     = (st_q != S_IDLE);
  assign cfg_prog_n_o = (st_q != S_PROG);
  assign busy_o       = (st_q != S_IDLE);
  assign fin_o        = (st_q == S_FIN);
  assign pass_o       = pass_q;
  assign err_o        = err_q;
endmodule

// File: rtl/ssl_loader_chk.sv
module ssl_loader_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cfg_en_o,
  input logic       cfg_prog_n_o,
  input logic       cfg_cclk_o,
  input logic       cfg_din_o,
  input logic       fin_o,
  input logic       pass_o,
  input logic [2:0] err_o
);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_en_o |-> (cfg_prog_n_o && !cfg_cclk_o && !cfg_din_o));

  p_prog_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_prog_n_o |=> cfg_prog_n_o);

  p_no_clk_in_prog_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_prog_n_o |-> !cfg_cclk_o);

  p_cclk_min_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_cclk_o) |=> cfg_cclk_o);

  p_cclk_max_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_cclk_o && $past(cfg_cclk_o)) |=> !cfg_cclk_o);

  p_din_setup_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_cclk_o) |-> $stable(cfg_din_o));

  p_din_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_cclk_o && $past(cfg_cclk_o)) |-> $stable(cfg_din_o));

  p_pass_code_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin_o && pass_o) |-> (err_o == 3'd0));

  p_fin_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_o |=> !fin_o);

  p_en_active_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_prog_n_o || cfg_cclk_o || fin_o) |-> cfg_en_o);
endmodule

bind ssl_loader ssl_loader_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_en_o     (cfg_en_o),
  .cfg_prog_n_o (cfg_prog_n_o),
  .cfg_cclk_o   (cfg_cclk_o),
  .cfg_din_o    (cfg_din_o),
  .fin_o        (fin_o),
  .pass_o       (pass_o),
  .err_o        (err_o)
);

// File: tb/test_ssl_loader.sv
`timescale 1ns/1ps
module test_ssl_loader;
  localparam int ADDR_W = 12;
  localparam int CLR_T  = 50;
  localparam int SET_T  = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [ADDR_W-1:0] len_r = '0;
  logic [ADDR_W-1:0] addr;
  logic [7:0] rdata = '0;
  logic tick = 1'b0;
  logic done_drv = 1'b1;
  logic en, prog_n, cclk, din, busy, fin, pass;
  logic [2:0] err;
  logic [7:0] mem [0:(1<<ADDR_W)-1];

  int checks = 0, failures = 0, cyc = 0, tdiv = 0;
  logic bits_q[$];
  int exp_nbits = 0, dmode = 0, prog_pulses = 0, prog_run = 0, hi_run = 0;
  int clr_ticks = 0, set_ticks = 0;
  logic clr_on = 0, set_on = 0, set_done = 0;
  logic prog_prev = 1'b1, cclk_prev = 1'b0, din_prev = 1'b0;

  always #10 clk = ~clk;

  ssl_loader #(.ADDR_W(ADDR_W), .CLEAR_MS(CLR_T), .SETTLE_MS(SET_T)) i_ssl_loader (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .img_len_i(len_r),
    .mem_addr_o(addr), .mem_rdata_i(rdata), .tick_i(tick),
    .cfg_en_o(en), .cfg_prog_n_o(prog_n), .cfg_cclk_o(cclk), .cfg_din_o(din),
    .cfg_done_i(done_drv), .busy_o(busy), .fin_o(fin), .pass_o(pass), .err_o(err)
  );

  always @(posedge clk) rdata <= mem[addr];

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // behavioural target and pin monitor, sampled away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!prog_n) begin
        prog_run++;
        if (prog_prev) prog_pulses++;
      end else begin
        if (!prog_prev) begin
          chk(prog_run == 1, "R5", "program low width", prog_run, 1);
          clr_on = 1;
        end
        prog_run = 0;
      end
      if (cclk && !cclk_prev) begin
        chk(din == din_prev, "R7", "data setup before clock rise", din, din_prev);
        bits_q.push_back(din);
        hi_run = 1;
        clr_on = 0;
      end else if (cclk) begin
        hi_run++;
        chk(din == din_prev, "R7", "data hold while clock high", din, din_prev);
      end else if (cclk_prev) begin
        chk(hi_run == 2, "R7", "clock high cycles", hi_run, 2);
      end
      if (!prog_n || cclk) chk(en, "R9", "enable during pin activity", en, 1);
      if (fin) begin clr_on = 0; set_on = 0; set_done = 1; end
      if (clr_on && tick) clr_ticks++;
      if (exp_nbits > 0 && bits_q.size() == exp_nbits && !cclk && !set_done) set_on = 1;
      if (set_on && tick) set_ticks++;
      if (dmode != 1) begin
        if (!prog_n) done_drv = 1'b0;
        else if (dmode == 0 && exp_nbits > 0 && bits_q.size() == exp_nbits) done_drv = 1'b1;
      end
    end
    prog_prev = prog_n;
    cclk_prev = cclk;
    din_prev  = din;
    tdiv = (tdiv == 6) ? 0 : tdiv + 1;
    tick = (tdiv == 0);
    if (cyc > 190000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 190000);
      finish_run();
    end
  end

  task automatic fill(input int from, input int to, input int seed);
    for (int i = from; i <= to; i++) mem[i] = 8'((i * 29 + seed) & 8'hFF);
  endtask

  // mode 0 normal target, 1 status stuck high, 2 status never rises
  task automatic run_case(input int len, input int mode, input int exp_code,
                          input int exp_sync, input string rq);
    int n;
    logic exp_q[$];
    exp_nbits = (exp_code == 0 || exp_code == 5) ? (len - exp_sync) * 8 : 0;
    for (int a = exp_sync; exp_nbits > 0 && a < len; a++)
      for (int b = 7; b >= 0; b--) exp_q.push_back(mem[a][b]);
    dmode = mode;
    done_drv = (mode != 2);
    bits_q.delete();
    prog_pulses = 0; clr_ticks = 0; set_ticks = 0;
    clr_on = 0; set_on = 0; set_done = 0;
    @(negedge clk);
    len_r = ADDR_W'(len);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!fin && n < 30000) begin @(negedge clk); n++; end
    chk(fin, rq, "run finished", fin, 1);
    chk(err == 3'(exp_code), rq, "reason code", err, exp_code);
    chk(pass == (exp_code == 0), rq, "pass flag", pass, exp_code == 0);
    chk(bits_q.size() == exp_q.size(), "R7", "bits shifted", bits_q.size(), exp_q.size());
    if (bits_q.size() == exp_q.size() && exp_q.size() > 0) begin
      int bad = 0;
      foreach (exp_q[k]) if (bits_q[k] !== exp_q[k]) bad++;
      chk(bad == 0, "R7", "bit stream MSB first mismatches", bad, 0);
    end
    n = (exp_code == 0 || exp_code >= 4) ? 1 : 0;
    chk(prog_pulses == n, (n == 0) ? "R4" : "R5", "program pulses", prog_pulses, n);
    if (n == 1)
      chk(clr_ticks == CLR_T || clr_ticks == CLR_T + 1, "R5", "clear wait ticks", clr_ticks, CLR_T);
    if (exp_nbits > 0)
      chk(set_ticks == SET_T || set_ticks == SET_T + 1, "R8", "settle wait ticks", set_ticks, SET_T);
    @(negedge clk);
    chk(!fin, "R9", "finish is one cycle", fin, 0);
    @(negedge clk);
    chk(!en && prog_n && !cclk && !din && !busy, "R1", "idle pins after run",
        {en, prog_n, cclk, din, busy}, 5'b01000);
    chk(err == 3'(exp_code) && pass == (exp_code == 0), "R9", "result held", err, exp_code);
  endtask

  initial begin
    for (int i = 0; i < (1 << ADDR_W); i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(!en && prog_n && !cclk && !din && !busy && !fin, "R1", "reset pin state",
        {en, prog_n, cclk, din, busy, fin}, 6'b010000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // sync at 3, count 160 bits, exact fit
    mem[0] = 8'h00; mem[1] = 8'h5A; mem[2] = 8'h7E; mem[3] = 8'hFF;
    mem[4] = 8'h20; mem[5] = 8'h00; mem[6] = 8'h0A; mem[7] = 8'h05;
    fill(8, 22, 11);
    run_case(23, 0, 0, 3, "R2");
    run_case(23, 1, 4, 3, "R6");
    run_case(23, 2, 5, 3, "R8");

    // sync at 0, count 167: floor(167/8)=20 fits length 20, not 19
    mem[0] = 8'hFF; mem[1] = 8'h20; mem[2] = 8'h00; mem[3] = 8'h0A; mem[4] = 8'h7C;
    fill(5, 19, 3);
    run_case(20, 0, 0, 0, "R4");
    run_case(19, 0, 3, 0, "R4");

    // tag low nibble non-zero accepted, large count spread over all bytes
    mem[1] = 8'h21; mem[2] = 8'hAB; mem[3] = 8'hCD; mem[4] = 8'hE0;
    run_case(40, 0, 3, 0, "R3");

    mem[1] = 8'h30;
    run_case(20, 0, 2, 0, "R3");

    // no sync inside the image, sync byte just past its end
    for (int i = 0; i < 10; i++) mem[i] = 8'(8'h10 + i);
    mem[10] = 8'hFF;
    run_case(10, 0, 1, 0, "R2");
    run_case(0, 0, 1, 0, "R2");

    finish_run();
  end
endmodule